// File: doc/BRIEF.md
# Register dependency interlock scoreboard

This block sits beside the decode stage of a dual-issue pipeline. For every general register, every floating-point register and the floating-point status register it keeps a small down-counter giving the cycles left before a pending result can be consumed. Each cycle up to two decoded instruction descriptors arrive: slot 0 is the older instruction and slot 1 is the younger. The block checks their source registers against the counters. It holds decode with a stall until slot 0's operands are ready, and it lets slot 1 go in the same cycle only when slot 1 does not depend on slot 0 in a way that forbids pairing.

How long a result stays unavailable depends on the consumer as well as the producer. A load result is one cycle later when it is used as a dynamic shift amount. A double-precision add frees its lower half one cycle before its upper half. A floating-point operation's effect on the status register has a latency of its own. Accepted instructions update the scoreboard, and a flush clears it in one cycle.

Register index map: 0..NGPR-1 are general registers, the next NFPR are floating-point registers, and the last index (32 by default) is the status register. Class codes on `sN_cls`: 0 move (zero latency), 1 integer ALU, 2 long-word load, 3 single FP arithmetic, 4 double FP add, 5 single-to-double conversion. Codes 6 and 7 write nothing. For classes 4 and 5, `sN_dst` names the lower half and `sN_dst`+1 names the upper half.

Top module: `dep_scoreboard`

## Requirements
- R1: A result of class 0 or class 1 can be read by an instruction presented one cycle after the producer issued, with no stall.
- R2: A consumer of a class 2 (load) result that is presented in the cycle right after the load is stalled exactly 1 cycle.
- R3: When the load result is read through source B with `sN_sb_shamt`=1, the consumer is stalled exactly 2 cycles.
- R4: `s1_go` is 0 when slot 1 reads slot 0's destination as its load address (`s1_sa_addr`=1), or reads it at all when slot 0's class is not 0. `s1_go` is 1 when slot 1 makes an ordinary read of a class 0 destination. `s1_go` is never 1 while `s0_go` is 0.
- R5: The consumer's stall is the producer latency minus the cycles already elapsed. A load followed by one unrelated instruction and then its consumer gives 0 stall cycles.
- R6: A class 3 or class 4 instruction makes the status register (last index) unreadable for 4 cycles after issue, so an immediate reader is stalled 3 cycles.
- R7: A class 4 result stalls an immediate reader of its lower half 6 cycles and of its upper half 7 cycles.
- R8: A class 5 result stalls an immediate reader of either half 2 cycles.
- R9: A new write to a register with a pending write keeps the larger of the remaining and the new latency.
- R10: A cycle with `flush`=1 accepts no instruction, and in the next cycle `busy` is all zero.
- R11: While `stall`=1, neither slot is accepted and no scoreboard entry is written, so the stalled instruction's destination stays not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear all pending counters, accept nothing |
| s0_vld | input | 1 | Slot 0 descriptor valid |
| s0_cls | input | 3 | Slot 0 latency class |
| s0_dst | input | AW | Slot 0 destination index |
| s0_dst_en | input | 1 | Slot 0 writes a destination |
| s0_sa | input | AW | Slot 0 source A index |
| s0_sa_en | input | 1 | Slot 0 source A used |
| s0_sa_addr | input | 1 | Slot 0 source A is a load address |
| s0_sb | input | AW | Slot 0 source B index |
| s0_sb_en | input | 1 | Slot 0 source B used |
| s0_sb_shamt | input | 1 | Slot 0 source B is a dynamic shift amount |
| s1_vld | input | 1 | Slot 1 descriptor valid |
| s1_cls | input | 3 | Slot 1 latency class |
| s1_dst | input | AW | Slot 1 destination index |
| s1_dst_en | input | 1 | Slot 1 writes a destination |
| s1_sa | input | AW | Slot 1 source A index |
| s1_sa_en | input | 1 | Slot 1 source A used |
| s1_sa_addr | input | 1 | Slot 1 source A is a load address |
| s1_sb | input | AW | Slot 1 source B index |
| s1_sb_en | input | 1 | Slot 1 source B used |
| s1_sb_shamt | input | 1 | Slot 1 source B is a dynamic shift amount |
| stall | output | 1 | Slot 0 valid but an operand is not ready |
| s0_go | output | 1 | Slot 0 issues this cycle |
| s1_go | output | 1 | Slot 1 issues this cycle |
| busy | output | NREG | Per-register pending-write flag |

## Verification
Two things can land on one register in the same cycle: the per-cycle drain of an old pending write, and a fresh write from a newly accepted instruction. The bench provokes this by issuing a double-precision add and, in the very next cycle, an integer write to the add's upper half. It then counts the stall cycles of a reader, which must follow the older, longer wait. The pairing check and the stall check also meet in one cycle, because slot 1 is judged against slot 0's destination while slot 0 itself is being cleared. Directed pairs with a move producer, an ALU producer and a load-address reader show `s1_go` following the dependency kind.

// File: rtl/dep_scoreboard.sv
module dep_scoreboard #(
  parameter int NGPR = 16,
  parameter int NFPR = 16,
  parameter int LAT_LOAD = 2,
  parameter int LAT_FSGL = 3,
  parameter int LAT_FSTAT = 4,
  parameter int LAT_DLO = 7,
  parameter int LAT_DHI = 8,
  parameter int LAT_CVT = 3,
  localparam int NREG = NGPR + NFPR + 1,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          s0_vld,
  input  logic [2:0]    s0_cls,
  input  logic [AW-1:0] s0_dst,
  input  logic          s0_dst_en,
  input  logic [AW-1:0] s0_sa,
  input  logic          s0_sa_en,
  input  logic          s0_sa_addr,
  input  logic [AW-1:0] s0_sb,
  input  logic          s0_sb_en,
  input  logic          s0_sb_shamt,
  input  logic          s1_vld,
  input  logic [2:0]    s1_cls,
  input  logic [AW-1:0] s1_dst,
  input  logic          s1_dst_en,
  input  logic [AW-1:0] s1_sa,
  input  logic          s1_sa_en,
  input  logic          s1_sa_addr,
  input  logic [AW-1:0] s1_sb,
  input  logic          s1_sb_en,
  input  logic          s1_sb_shamt,
  output logic          stall,
  output logic          s0_go,
  output logic          s1_go,
  output logic [NREG-1:0] busy
);
  localparam int CW = $clog2(LAT_DHI + 1);
  localparam int ST = NREG - 1;
  localparam logic [2:0] C_MOV = 3'd0, C_ALU = 3'd1, C_LD = 3'd2,
                         C_FS = 3'd3, C_FD = 3'd4, C_CV = 3'd5;

  logic [CW-1:0] cnt [NREG];
  logic          ldf [NREG];
  logic [CW-1:0] cnt_n [NREG];
  logic          ldf_n [NREG];

  // returns {hit, load_flag, count}
  function automatic logic [CW+1:0] wr(input logic [2:0] c, input logic [AW-1:0] d,
                                       input logic de, input int r);
    logic h, l;
    logic [CW-1:0] v;
    h = 1'b0; l = 1'b0; v = '0;
    case (c)
      C_MOV, C_ALU: h = de && int'(d) == r;
      C_LD: begin h = de && int'(d) == r; l = 1'b1; v = CW'(LAT_LOAD); end
      C_FS: begin
        if (r == ST) begin h = 1'b1; v = CW'(LAT_FSTAT - 1); end
        else if (de && int'(d) == r) begin h = 1'b1; v = CW'(LAT_FSGL - 1); end
      end
      C_FD: begin
        if (r == ST) begin h = 1'b1; v = CW'(LAT_FSTAT - 1); end
        else if (de && int'(d) == r) begin h = 1'b1; v = CW'(LAT_DLO - 1); end
        else if (de && int'(d) + 1 == r) begin h = 1'b1; v = CW'(LAT_DHI - 1); end
      end
      C_CV: begin
        h = de && (int'(d) == r || int'(d) + 1 == r);
        v = CW'(LAT_CVT - 1);
      end
      default: h = 1'b0;
    endcase
    return {h, l, v};
  endfunction

  function automatic logic rdy(input logic [AW-1:0] s, input logic en, input logic sh);
    if (!en || int'(s) >= NREG) return 1'b1;
    return cnt[s] == '0 || (!sh && ldf[s] && cnt[s] == CW'(1));
  endfunction

  function automatic logic [CW:0] mrg(input logic [CW:0] a, input logic [CW:0] b);
    if (b[CW-1:0] > a[CW-1:0]) return b;
    if (a[CW-1:0] > b[CW-1:0]) return a;
    return {a[CW] & b[CW], a[CW-1:0]};
  endfunction

  logic rdy0, rdy1, veto;
  logic [CW+1:0] da, db;

  assign rdy0 = rdy(s0_sa, s0_sa_en, 1'b0) && rdy(s0_sb, s0_sb_en, s0_sb_shamt);
  assign rdy1 = rdy(s1_sa, s1_sa_en, 1'b0) && rdy(s1_sb, s1_sb_en, s1_sb_shamt);
  assign da = wr(s0_cls, s0_dst, s0_dst_en, int'(s1_sa));
  assign db = wr(s0_cls, s0_dst, s0_dst_en, int'(s1_sb));
  assign veto = (s1_sa_en && da[CW+1] && (s0_cls != C_MOV || s1_sa_addr)) ||
                (s1_sb_en && db[CW+1] && s0_cls != C_MOV);

  assign s0_go = s0_vld && !flush && rdy0;
  assign stall = s0_vld && !flush && !rdy0;
  assign s1_go = s0_go && s1_vld && rdy1 && !veto;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      logic [CW:0] e;
      logic [CW+1:0] w;
      e = {ldf[r], (cnt[r] != '0) ? cnt[r] - CW'(1) : cnt[r]};
      w = wr(s0_cls, s0_dst, s0_dst_en, r);
      if (s0_go && w[CW+1]) e = mrg(e, w[CW:0]);
      w = wr(s1_cls, s1_dst, s1_dst_en, r);
      if (s1_go && w[CW+1]) e = mrg(e, w[CW:0]);
      if (flush) e = '0;
      cnt_n[r] = e[CW-1:0];
      ldf_n[r] = e[CW];
      busy[r] = cnt[r] != '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin cnt[r] <= '0; ldf[r] <= 1'b0; end
    end else begin
      for (int r = 0; r < NREG; r++) begin cnt[r] <= cnt_n[r]; ldf[r] <= ldf_n[r]; end
    end
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> busy == '0);
  // R10
  flush_noissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !s0_go && !s1_go);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !s0_go && !s1_go);
  // R4
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_go |-> s0_go);
  // R4
  addr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_go && s0_dst_en && s1_sa_en && s1_sa_addr && s1_sa == s0_dst) |-> !s1_go);
  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_go && s0_cls == C_LD && s0_dst_en && int'(s0_dst) < NREG) |=> busy[$past(s0_dst)]);
endmodule

// File: tb/dep_scoreboard_test.sv
module dep_scoreboard_test;
  localparam int AW = 6;
  localparam int ST = 32;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic s0_vld = 0, s0_dst_en = 0, s0_sa_en = 0, s0_sa_addr = 0, s0_sb_en = 0, s0_sb_shamt = 0;
  logic s1_vld = 0, s1_dst_en = 0, s1_sa_en = 0, s1_sa_addr = 0, s1_sb_en = 0, s1_sb_shamt = 0;
  logic [2:0] s0_cls = 0, s1_cls = 0;
  logic [AW-1:0] s0_dst = 0, s0_sa = 0, s0_sb = 0, s1_dst = 0, s1_sa = 0, s1_sb = 0;
  logic stall, s0_go, s1_go;
  logic [32:0] busy;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dep_scoreboard uut (.*);

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    s0_vld = 0; s1_vld = 0; s0_dst_en = 0; s1_dst_en = 0;
    s0_sa_en = 0; s0_sb_en = 0; s0_sa_addr = 0; s0_sb_shamt = 0;
    s1_sa_en = 0; s1_sb_en = 0; s1_sa_addr = 0; s1_sb_shamt = 0;
  endtask

  task automatic settle();
    @(negedge clk); idle();
    repeat (10) @(negedge clk);
  endtask

  // call at a negedge; issues a producer in slot 0
  task automatic prod(input logic [2:0] c, input int d);
    idle(); s0_vld = 1; s0_cls = c; s0_dst = AW'(d); s0_dst_en = 1;
    #1;
    @(negedge clk);
  endtask

  // presents a consumer in slot 0 and counts stall cycles until it issues
  task automatic cons(input int sa, input bit sh, output int n);
    idle(); s0_vld = 1; s0_cls = 3'd1;
    if (sh) begin s0_sb = AW'(sa); s0_sb_en = 1; s0_sb_shamt = 1; end
    else begin s0_sa = AW'(sa); s0_sa_en = 1; end
    n = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (s0_go) break;
      n++;
      @(negedge clk);
    end
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset busy", int'(busy != 0), 0);
    chk("R11 reset stall", int'(stall), 0);
  endtask

  task automatic t_zero();
    int n;
    @(negedge clk); prod(3'd0, 1); cons(1, 0, n); chk("R1 move", n, 0);
    settle(); prod(3'd1, 2); cons(2, 0, n); chk("R1 alu", n, 0);
    settle();
  endtask

  task automatic t_load();
    int n;
    @(negedge clk); prod(3'd2, 3); cons(3, 0, n); chk("R2 load", n, 1);
    settle(); prod(3'd2, 3); cons(3, 1, n); chk("R3 load shamt", n, 2);
    settle(); prod(3'd2, 4);
    idle(); s0_vld = 1; s0_cls = 3'd0; #1; @(negedge clk);
    cons(4, 0, n); chk("R5 elapsed", n, 0);
    settle();
  endtask

  task automatic t_pair();
    @(negedge clk); idle();
    s0_vld = 1; s0_cls = 3'd1; s0_dst = 6'd5; s0_dst_en = 1;
    s1_vld = 1; s1_cls = 3'd1; s1_sa = 6'd5; s1_sa_en = 1; s1_sa_addr = 1;
    #1; chk("R4 addr pair s0", int'(s0_go), 1); chk("R4 addr pair s1", int'(s1_go), 0);
    @(negedge clk); settle();
    s0_vld = 1; s0_cls = 3'd0; s0_dst = 6'd6; s0_dst_en = 1;
    s1_vld = 1; s1_cls = 3'd1; s1_sa = 6'd6; s1_sa_en = 1;
    #1; chk("R4 move pair ordinary", int'(s1_go), 1);
    s1_sa_addr = 1;
    #1; chk("R4 move pair addr", int'(s1_go), 0);
    s1_sa_addr = 0; s0_cls = 3'd1;
    #1; chk("R4 alu pair ordinary", int'(s1_go), 0);
    @(negedge clk); settle();
  endtask

  task automatic t_fp();
    int n;
    @(negedge clk); prod(3'd3, 20); cons(ST, 0, n); chk("R6 status", n, 3);
    settle(); prod(3'd4, 18); cons(ST, 0, n); chk("R6 status dbl", n, 3);
    settle(); prod(3'd4, 18); cons(18, 0, n); chk("R7 lower", n, 6);
    settle(); prod(3'd4, 18); cons(19, 0, n); chk("R7 upper", n, 7);
    settle(); prod(3'd5, 22); cons(22, 0, n); chk("R8 cvt lower", n, 2);
    settle(); prod(3'd5, 22); cons(23, 0, n); chk("R8 cvt upper", n, 2);
    settle();
  endtask

  task automatic t_merge();
    int n;
    @(negedge clk); prod(3'd4, 18); prod(3'd1, 19);
    cons(19, 0, n); chk("R9 keep longer", n, 6);
    settle(); prod(3'd1, 7); prod(3'd2, 7);
    cons(7, 0, n); chk("R9 take new", n, 1);
    settle();
  endtask

  task automatic t_flush();
    int n;
    @(negedge clk); prod(3'd4, 18);
    idle(); flush = 1; s0_vld = 1; s0_cls = 3'd1; s0_dst = 6'd9; s0_dst_en = 1;
    #1; chk("R10 no issue", int'(s0_go), 0);
    @(negedge clk); flush = 0; idle();
    chk("R10 busy clear", int'(busy != 0), 0);
    cons(19, 0, n); chk("R10 after flush", n, 0);
    settle();
  endtask

  task automatic t_stallwr();
    @(negedge clk); prod(3'd4, 18);
    idle(); s0_vld = 1; s0_cls = 3'd2; s0_dst = 6'd5; s0_dst_en = 1; s0_sa = 6'd18; s0_sa_en = 1;
    s1_vld = 1; s1_cls = 3'd1; s1_dst = 6'd8; s1_dst_en = 1;
    #1; chk("R11 stall", int'(stall), 1); chk("R11 s1 held", int'(s1_go), 0);
    @(negedge clk);
    chk("R11 dst not busy", int'(busy[5]), 0);
    chk("R11 s1 dst not busy", int'(busy[8]), 0);
    settle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero();
    t_load();
    t_pair();
    t_fp();
    t_merge();
    t_flush();
    t_stallwr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule